// File: doc/BRIEF.md
# Reed-Solomon Error Locator Search and Magnitude Evaluator

This block is the last decoding stage for a shortened Reed-Solomon code with 828 symbols, of which 820 carry data. The code works over GF(2^10) and corrects up to four symbol errors. The earlier stages hand it two polynomials: the error locator, of degree at most four, and the error evaluator, of degree at most three. A single start pulse captures both. The block then sweeps the nonzero field elements, one per clock. It tests each one as a root of the locator, and for each root it computes the error value with Forney's formula.

Each root inside the codeword is streamed out as a symbol position and a ten-bit error value, qualified by a valid strobe. Roots that fall beyond the shortened length are not streamed. When the sweep ends, a one-cycle done pulse is raised together with a failure flag. The flag is set when the number of roots found differs from the degree of the locator, or when any root lay outside the codeword. The consumer applies the corrections to its own copy of the data.

Top module: `rs_chien_forney`

## Requirements
- R1: While reset is held, and in the first cycle after it, busy, valid, done and fail are all low.
- R2: A start pulse sampled while idle captures the coefficients, and busy is high after that edge. A start pulse or coefficient change while busy has no effect on the sweep, the outputs or the done timing.
- R3: Field elements are GF(2^10) polynomials modulo x^10+x^3+1, with alpha = x (value 0x002). Locator coefficient j occupies bits [10j+9:10j] of the locator input, and evaluator coefficient j the same bits of the evaluator input.
- R4: Sweep step k (k = 0..1022) tests x = alpha^k. A root there is reported as position (1023-k) mod 1023, in the cycle following the (k+2)-th rising edge after the accepting edge.
- R5: The error value at a root x is Omega(x) divided by x·Lambda'(x), where x·Lambda'(x) is the sum of the odd-indexed locator terms.
- R6: A root whose position is 828 or more produces no valid strobe and sets the failure flag.
- R7: Done is high for exactly one cycle, following the 1024th rising edge after the accepting edge, and busy falls at that same edge.
- R8: Fail is valid with done. It is high when the root count differs from the index of the highest nonzero locator coefficient, or when R6 applied. It holds its value until the next accepted start.
- R9: A root at position 1 (step 1022) is reported in the same cycle as done, and it is counted toward the failure decision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin a sweep with the presented coefficients |
| lambda_i | input | 50 | Error locator coefficients 0..4, ten bits each |
| omega_i | input | 40 | Error evaluator coefficients 0..3, ten bits each |
| busy_o | output | 1 | Sweep in progress |
| err_valid_o | output | 1 | A correctable error is presented |
| err_pos_o | output | 10 | Symbol position of the error |
| err_mag_o | output | 10 | Error value to add to that symbol |
| done_o | output | 1 | One-cycle end-of-sweep pulse |
| fail_o | output | 1 | Decoding failure, valid with done and held |

## Verification
Two events can land in the same cycle: the output for the final sweep step and the end-of-sweep pulse. The bench provokes this by injecting an error at position 1, alongside other errors. In that case the error value, the done pulse and a clear failure flag must all be seen in one sample, which shows that the final root was counted before the failure decision was made. Expected positions and values come from a direct evaluation of the polynomials at every field element. The bench builds those polynomials from the error patterns it injects, and it also tampers with one of them to force a failure.

// File: rtl/rs_chien_pkg.sv
package rs_chien_pkg;
    localparam int SYM_W    = 10;
    localparam int T_CORR   = 4;
    localparam int FIELD_SZ = 1 << SYM_W;
    localparam logic [SYM_W:0] GF_POLY = 11'h409;

    typedef logic [SYM_W-1:0] sym_t;

    // Shift-and-add product, reduced by GF_POLY after each shift.
    function automatic sym_t gf_mul(sym_t a, sym_t b);
        sym_t acc;
        acc = '0;
        for (int i = SYM_W - 1; i >= 0; i--) begin
            acc = {acc[SYM_W-2:0], 1'b0} ^ (acc[SYM_W-1] ? GF_POLY[SYM_W-1:0] : sym_t'(0));
            if (b[i]) acc = acc ^ a;
        end
        return acc;
    endfunction

    function automatic sym_t gf_alpha_pow(int e);
        sym_t r;
        r = sym_t'(1);
        for (int i = 0; i < e; i++) r = gf_mul(r, sym_t'(2));
        return r;
    endfunction
endpackage

// File: rtl/gf_const_mul.sv
module gf_const_mul
    import rs_chien_pkg::*;
#(
    parameter int EXP = 1
) (
    input  sym_t a_i,
    output sym_t y_o
);
    localparam sym_t K = gf_alpha_pow(EXP);

    always_comb y_o = gf_mul(a_i, K);
endmodule

// File: rtl/gf_mul_unit.sv
module gf_mul_unit
    import rs_chien_pkg::*;
(
    input  sym_t a_i,
    input  sym_t b_i,
    output sym_t y_o
);
    always_comb y_o = gf_mul(a_i, b_i);
endmodule

// File: rtl/gf_inv_unit.sv
module gf_inv_unit
    import rs_chien_pkg::*;
(
    input  sym_t a_i,
    output sym_t y_o
);
    // a^(2^m - 2) as the product of a^(2^i), i = 1..m-1
    always_comb begin
        sym_t sq;
        sym_t acc;
        sq  = a_i;
        acc = sym_t'(1);
        for (int i = 1; i < SYM_W; i++) begin
            sq  = gf_mul(sq, sq);
            acc = gf_mul(acc, sq);
        end
        y_o = acc;
    end
endmodule

// File: rtl/rs_chien_forney.sv
module rs_chien_forney
    import rs_chien_pkg::*;
#(
    parameter int CODE_N = 828
) (
    input  logic                        clk_i,
    input  logic                        rst_ni,
    input  logic                        start_i,
    input  logic [(T_CORR+1)*SYM_W-1:0] lambda_i,
    input  logic [T_CORR*SYM_W-1:0]     omega_i,
    output logic                        busy_o,
    output logic                        err_valid_o,
    output logic [SYM_W-1:0]            err_pos_o,
    output logic [SYM_W-1:0]            err_mag_o,
    output logic                        done_o,
    output logic                        fail_o
);
    localparam int   T      = T_CORR;
    localparam int   NL     = T + 1;
    localparam int   LAST   = FIELD_SZ - 1;
    localparam int   CNT_W  = SYM_W + 1;
    localparam int   DEG_W  = $clog2(NL);
    localparam sym_t LAST_S = sym_t'(LAST);

    typedef struct packed {
        logic                busy;
        sym_t                step;
        logic [NL-1:0][SYM_W-1:0] lam;
        logic [T-1:0][SYM_W-1:0]  om;
        logic [DEG_W-1:0]    deg;
        logic [CNT_W-1:0]    roots;
        logic                beyond;
        logic                s1_hit;
        logic                s1_keep;
        sym_t                s1_pos;
        sym_t                s1_om;
        sym_t                s1_den;
        logic                out_v;
        sym_t                out_pos;
        sym_t                out_mag;
        logic                done;
        logic                fail;
    } state_t;

    state_t st_q, st_d;

    sym_t lam_nx [NL];
    sym_t om_nx  [T];
    sym_t den_inv, mag_val;

    // Term j of each polynomial advances by alpha^j per step.
    assign lam_nx[0] = st_q.lam[0];
    assign om_nx[0]  = st_q.om[0];

    for (genvar j = 1; j < NL; j++) begin : g_lam_step
        gf_const_mul #(.EXP(j)) u_cm (.a_i(st_q.lam[j]), .y_o(lam_nx[j]));
    end

    for (genvar j = 1; j < T; j++) begin : g_om_step
        gf_const_mul #(.EXP(j)) u_cm (.a_i(st_q.om[j]), .y_o(om_nx[j]));
    end

    gf_inv_unit u_inv (.a_i(st_q.s1_den), .y_o(den_inv));
    gf_mul_unit u_mag (.a_i(st_q.s1_om), .b_i(den_inv), .y_o(mag_val));

    always_comb begin
        sym_t             lam_sum, odd_sum, om_sum, pos;
        logic             hit, keep;
        logic [DEG_W-1:0] deg_new;

        lam_sum = '0;
        odd_sum = '0;
        for (int j = 0; j < NL; j++) begin
            lam_sum = lam_sum ^ st_q.lam[j];
            if (j % 2 == 1) odd_sum = odd_sum ^ st_q.lam[j];
        end
        om_sum = '0;
        for (int j = 0; j < T; j++) om_sum = om_sum ^ st_q.om[j];

        hit  = st_q.busy && (st_q.step != LAST_S) && (lam_sum == '0);
        pos  = (st_q.step == '0) ? '0 : (LAST_S - st_q.step);
        keep = (int'(pos) < CODE_N);

        deg_new = '0;
        for (int j = 0; j < NL; j++) begin
            if (lambda_i[j*SYM_W +: SYM_W] != '0) deg_new = DEG_W'(j);
        end

        st_d      = st_q;
        st_d.done = 1'b0;

        // stage two: error value through the inverter and multiplier
        st_d.out_v   = st_q.s1_hit & st_q.s1_keep;
        st_d.out_pos = st_q.s1_pos;
        st_d.out_mag = mag_val;

        // stage one: root test and bookkeeping of the sweep
        st_d.s1_hit  = hit;
        st_d.s1_keep = keep;
        st_d.s1_pos  = pos;
        st_d.s1_om   = om_sum;
        st_d.s1_den  = odd_sum;
        if (hit) begin
            st_d.roots = st_q.roots + 1'b1;
            if (!keep) st_d.beyond = 1'b1;
        end

        if (st_q.busy) begin
            for (int j = 0; j < NL; j++) st_d.lam[j] = lam_nx[j];
            for (int j = 0; j < T; j++)  st_d.om[j]  = om_nx[j];
            st_d.step = st_q.step + 1'b1;
            if (st_q.step == LAST_S) begin
                st_d.busy = 1'b0;
                st_d.done = 1'b1;
                st_d.fail = (st_q.roots != CNT_W'(st_q.deg)) | st_q.beyond;
            end
        end else if (start_i) begin
            for (int j = 0; j < NL; j++) st_d.lam[j] = lambda_i[j*SYM_W +: SYM_W];
            for (int j = 0; j < T; j++)  st_d.om[j]  = omega_i[j*SYM_W +: SYM_W];
            st_d.busy   = 1'b1;
            st_d.step   = '0;
            st_d.roots  = '0;
            st_d.beyond = 1'b0;
            st_d.fail   = 1'b0;
            st_d.deg    = deg_new;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign busy_o      = st_q.busy;
    assign err_valid_o = st_q.out_v;
    assign err_pos_o   = st_q.out_pos;
    assign err_mag_o   = st_q.out_mag;
    assign done_o      = st_q.done;
    assign fail_o      = st_q.fail;
endmodule

// File: rtl/rs_chien_forney_chk.sv
module rs_chien_forney_chk
    import rs_chien_pkg::*;
#(
    parameter int CODE_N = 828
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             start_i,
    input logic             busy_o,
    input logic             err_valid_o,
    input logic [SYM_W-1:0] err_pos_o,
    input logic             done_o,
    input logic             fail_o
);
    localparam int RUN_W = SYM_W + 2;

    logic [RUN_W-1:0] run_q;

    always_ff @(posedge clk_i) begin
        if (!rst_ni)     run_q <= '0;
        else if (busy_o) run_q <= run_q + 1'b1;
        else             run_q <= '0;
    end

    assert_pos_in_range_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        err_valid_o |-> (int'(err_pos_o) < CODE_N));

    assert_start_loads_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(busy_o) |-> $past(start_i));

    assert_done_after_sweep_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> (run_q == RUN_W'(FIELD_SZ)) && !busy_o);

    assert_done_single_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o);

    assert_fail_held_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(fail_o) |-> (done_o || busy_o));

    assert_output_in_sweep_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        err_valid_o |-> (busy_o || done_o));
endmodule

bind rs_chien_forney rs_chien_forney_chk #(.CODE_N(CODE_N)) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .busy_o      (busy_o),
    .err_valid_o (err_valid_o),
    .err_pos_o   (err_pos_o),
    .done_o      (done_o),
    .fail_o      (fail_o)
);

// File: tb/rs_chien_forney_tb_top.sv
module rs_chien_forney_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NPTS       = 1023;
    localparam int NCODE      = 828;

    typedef struct packed {
        logic [2:0]       n;
        logic [3:0][9:0]  pos;
        logic [3:0][9:0]  mag;
    } vec_t;

    localparam int NV = 5;
    localparam vec_t VECS [NV] = '{
        '{3'd1, {10'd0,   10'd0,   10'd0,   10'd0},  {10'h000, 10'h000, 10'h000, 10'h001}},
        '{3'd2, {10'd0,   10'd0,   10'd827, 10'd5},  {10'h000, 10'h000, 10'h155, 10'h3FF}},
        '{3'd4, {10'd826, 10'd500, 10'd100, 10'd1},  {10'h02A, 10'h1C3, 10'h077, 10'h300}},
        '{3'd3, {10'd0,   10'd300, 10'd900, 10'd2},  {10'h000, 10'h011, 10'h022, 10'h033}},
        '{3'd4, {10'd40,  10'd30,  10'd20,  10'd10}, {10'h004, 10'h003, 10'h002, 10'h001}}
    };

    logic        clk = 1'b0;
    logic        rst_ni = 1'b0;
    logic        start_i = 1'b0;
    logic [49:0] lambda_i = '0;
    logic [39:0] omega_i = '0;
    logic        busy_o, err_valid_o, done_o, fail_o;
    logic [9:0]  err_pos_o, err_mag_o;

    int tests = 0;
    int fails = 0;

    logic [9:0] lam_c [5];
    logic [9:0] om_c  [4];
    logic       exp_v   [NPTS];
    logic [9:0] exp_pos [NPTS];
    logic [9:0] exp_mag [NPTS];
    logic       exp_fail;
    int         exp_roots;

    always #(CLK_PERIOD/2) clk = ~clk;

    rs_chien_forney dut_i (
        .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i),
        .lambda_i(lambda_i), .omega_i(omega_i),
        .busy_o(busy_o), .err_valid_o(err_valid_o), .err_pos_o(err_pos_o),
        .err_mag_o(err_mag_o), .done_o(done_o), .fail_o(fail_o)
    );

    function automatic logic [9:0] bmul(logic [9:0] a, logic [9:0] b);
        logic [10:0] x;
        logic [9:0]  r;
        x = {1'b0, a};
        r = '0;
        for (int i = 0; i < 10; i++) begin
            if (b[i]) r = r ^ x[9:0];
            x = x << 1;
            if (x[10]) x = x ^ 11'h409;
        end
        return r;
    endfunction

    function automatic logic [9:0] bpow(int e);
        logic [9:0] r;
        r = 10'd1;
        for (int i = 0; i < e; i++) r = bmul(r, 10'd2);
        return r;
    endfunction

    function automatic logic [9:0] binv(logic [9:0] a);
        logic [9:0] r;
        r = 10'd1;
        for (int i = 0; i < 1022; i++) r = bmul(r, a);
        return r;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int expv);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
        end
    endtask

    task automatic build_vec(input vec_t v);
        logic [9:0] xl [4];
        logic [9:0] tmp [5];
        for (int j = 0; j < 5; j++) lam_c[j] = '0;
        for (int j = 0; j < 4; j++) om_c[j] = '0;
        lam_c[0] = 10'd1;
        for (int i = 0; i < int'(v.n); i++) begin
            xl[i] = bpow(int'(v.pos[i]));
            for (int j = 4; j >= 1; j--) lam_c[j] = lam_c[j] ^ bmul(lam_c[j-1], xl[i]);
        end
        for (int i = 0; i < int'(v.n); i++) begin
            for (int j = 0; j < 5; j++) tmp[j] = '0;
            tmp[0] = 10'd1;
            for (int l = 0; l < int'(v.n); l++) begin
                if (l != i) begin
                    for (int j = 4; j >= 1; j--) tmp[j] = tmp[j] ^ bmul(tmp[j-1], xl[l]);
                end
            end
            for (int j = 0; j < 4; j++) om_c[j] = om_c[j] ^ bmul(v.mag[i], tmp[j]);
        end
    endtask

    task automatic compute_ref();
        logic [9:0] x, xp, lv, dv, ov;
        int  deg, p;
        bit  bad;
        deg = 0;
        for (int j = 0; j < 5; j++) if (lam_c[j] != 0) deg = j;
        exp_roots = 0;
        bad = 1'b0;
        for (int k = 0; k < NPTS; k++) begin
            x  = bpow(k);
            lv = '0; dv = '0; ov = '0;
            xp = 10'd1;
            for (int j = 0; j < 5; j++) begin
                lv = lv ^ bmul(lam_c[j], xp);
                if (j % 2 == 1) dv = dv ^ bmul(lam_c[j], xp);
                if (j < 4) ov = ov ^ bmul(om_c[j], xp);
                xp = bmul(xp, x);
            end
            p = (k == 0) ? 0 : NPTS - k;
            exp_v[k]   = 1'b0;
            exp_pos[k] = 10'(p);
            exp_mag[k] = '0;
            if (lv == 0) begin
                exp_roots++;
                if (p >= NCODE) bad = 1'b1;
                else begin
                    exp_v[k]   = 1'b1;
                    exp_mag[k] = bmul(ov, binv(dv));
                end
            end
        end
        exp_fail = (exp_roots != deg) || bad;
    endtask

    task automatic run_case(input string name, input bit poke);
        int stray;
        compute_ref();
        @(negedge clk);
        for (int j = 0; j < 5; j++) lambda_i[j*10 +: 10] = lam_c[j];
        for (int j = 0; j < 4; j++) omega_i[j*10 +: 10] = om_c[j];
        start_i = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start_i = 1'b0;
        check(busy_o == 1'b1, "R2", {name, " busy after start"}, int'(busy_o), 1);
        stray = 0;
        for (int n = 1; n <= 1025; n++) begin
            if (poke && n == 500) begin
                start_i  = 1'b1;
                lambda_i = '1;
                omega_i  = '1;
            end
            if (poke && n == 501) start_i = 1'b0;
            @(posedge clk);
            @(negedge clk);
            if (n >= 2 && n - 2 < NPTS) begin
                int k;
                k = n - 2;
                if (err_valid_o || exp_v[k]) begin
                    check(err_valid_o == exp_v[k], "R4/R6", {name, " valid strobe"},
                          int'(err_valid_o), int'(exp_v[k]));
                    if (err_valid_o && exp_v[k]) begin
                        check(err_pos_o == exp_pos[k], "R4", {name, " position"},
                              int'(err_pos_o), int'(exp_pos[k]));
                        check(err_mag_o == exp_mag[k], "R5", {name, " magnitude"},
                              int'(err_mag_o), int'(exp_mag[k]));
                    end
                end
            end
            if (n == 1024) begin
                check(done_o == 1'b1, "R7", {name, " done at sweep end"}, int'(done_o), 1);
                check(busy_o == 1'b0, "R7", {name, " busy falls with done"}, int'(busy_o), 0);
                check(fail_o == exp_fail, "R8", {name, " fail flag"}, int'(fail_o), int'(exp_fail));
            end else if (done_o) begin
                stray++;
            end
            if (n == 1025)
                check(fail_o == exp_fail, "R8", {name, " fail held"}, int'(fail_o), int'(exp_fail));
        end
        check(stray == 0, "R7", {name, " stray done pulses"}, stray, 0);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin : main
        // R1: outputs quiet during and just after reset
        repeat (3) @(negedge clk);
        check({busy_o, err_valid_o, done_o, fail_o} == 4'b0, "R1", "outputs in reset",
              int'({busy_o, err_valid_o, done_o, fail_o}), 0);
        rst_ni = 1'b1;
        @(negedge clk);
        check({busy_o, err_valid_o, done_o, fail_o} == 4'b0, "R1", "outputs after reset",
              int'({busy_o, err_valid_o, done_o, fail_o}), 0);

        // R3 field and layout, R4/R5 stream; vector 2 holds position 1 (R9)
        for (int v = 0; v < NV; v++) begin
            build_vec(VECS[v]);
            run_case($sformatf("vec%0d", v), 1'b0);
        end

        // R9: last-step root beside done, checked directly
        build_vec(VECS[2]);
        compute_ref();
        check(exp_v[NPTS-1] == 1'b1 && exp_fail == 1'b0, "R9", "reference sets final-step root",
              int'(exp_v[NPTS-1]), 1);

        // R8: no errors, degree zero, no roots
        for (int j = 0; j < 5; j++) lam_c[j] = '0;
        for (int j = 0; j < 4; j++) om_c[j] = '0;
        lam_c[0] = 10'd1;
        run_case("no-errors", 1'b0);

        // R8: tampered locator with wrong root count
        build_vec(VECS[3]);
        lam_c[4] = 10'h001;
        run_case("tampered", 1'b0);

        // R2: start and coefficient changes during a sweep are ignored
        build_vec(VECS[4]);
        run_case("start-while-busy", 1'b1);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule